// File: doc/BRIEF.md
# Double-Buffered Serial Front End for a Segmented 16-bit DAC

This block is the digital front end of a 16-bit converter. Words arrive on a three- or four-wire serial link made of a frame strobe, a serial clock and a data line. They are shifted into a serial staging register. A second register, the DAC holding register, drives the converter core. Because the two registers are separate, a new word can be preloaded without disturbing the present output.

The staging register is copied into the holding register in two cases:

- when the frame strobe returns high while a load strobe is low;
- on its own, whenever the load strobe is pulled low.

A falling-edge clear zeroes both registers, and it blocks every transfer for as long as it stays low.

The holding register drives a segmented core. Its top four bits become fifteen equal-weight thermometer enables. Its low twelve bits pass straight to the binary ladder switches.

All pins are asynchronous to the system clock. Each pin passes through a two-flop synchroniser before edges are detected. The system clock must run at least four times faster than the serial clock.

Top module: `sdac_front`

## Requirements
- R1: While reset is held and after it is released, `dac_code`, `seg_en` and `ladder_sw` are all zero and `dac_update` is low.
- R2: A data bit is shifted into the staging register, most significant bit first, on each synchronised rising edge of `ser_clk` that occurs while `frame_n` is low. Serial clock edges that occur while `frame_n` is high leave the staging register unchanged.
- R3: If a frame carries more than 16 bits, the staging register keeps only the last 16 bits received.
- R4: If a frame carries n < 16 bits, the staging register holds the previous contents shifted up by n places, with the n new bits in the low positions.
- R5: When `frame_n` rises while `load_n` is low, the staging register is copied into `dac_code` exactly once, even if `load_n` falls in the same cycle. The copy is accompanied by one single-cycle `dac_update` pulse. `dac_code` changes on the third system clock rising edge after the pin edge.
- R6: When `frame_n` rises while `load_n` is high, `dac_code` does not change. A later falling edge on `load_n` copies the staging register into `dac_code` with one `dac_update` pulse.
- R7: A falling edge on `zero_n` sets both the staging register and `dac_code` to zero, with one `dac_update` pulse, including when it arrives in the middle of a frame. Bits shifted in after the clear are kept.
- R8: While `zero_n` stays low, neither a `load_n` falling edge nor a `frame_n` rising edge transfers anything and `dac_update` stays low. Releasing `zero_n` causes no transfer.
- R9: `seg_en[i]` is 1 exactly when `dac_code[15:12]` is greater than i, for i = 0 to 14, so the code selects a thermometer pattern. `ladder_sw` equals `dac_code[11:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data is captured on its rising edge |
| ser_dat | input | 1 | Serial data, most significant bit first |
| frame_n | input | 1 | Active-low frame strobe; its rising edge may trigger a transfer |
| load_n | input | 1 | Active-low load strobe; its falling edge triggers a transfer |
| zero_n | input | 1 | Active-low clear; its falling edge zeroes both registers |
| dac_code | output | 16 | DAC holding register |
| seg_en | output | 15 | Thermometer enables decoded from the top four code bits |
| ladder_sw | output | 12 | Binary ladder switch controls, equal to the low code bits |
| dac_update | output | 1 | One-cycle pulse when the holding register is loaded or cleared |

## Verification
A pin edge passes through two synchroniser flops and then an edge-detect flop. `dac_code` and `dac_update` therefore change on the third system clock rising edge after the pin moves. The decoded `seg_en` and `ladder_sw` follow in the same cycle, because they are combinational from `dac_code`. The bench drives pins on falling clock edges and normally waits six cycles before comparing. The latency test samples one cycle before and exactly at the third edge to pin down R5. Transfers are counted by tallying `dac_update` pulses on falling clock edges, and the tally is compared with the number the bench model expects.

// File: rtl/sdac_front.sv
module sdac_front #(
  parameter int WIDTH       = 16,
  parameter int SEG_BITS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ser_clk,
  input  logic                       ser_dat,
  input  logic                       frame_n,
  input  logic                       load_n,
  input  logic                       zero_n,
  output logic [WIDTH-1:0]           dac_code,
  output logic [(2**SEG_BITS)-2:0]   seg_en,
  output logic [WIDTH-SEG_BITS-1:0]  ladder_sw,
  output logic                       dac_update
);
  localparam int SEGS = (2**SEG_BITS) - 1;
  localparam int NPIN = 5;
  localparam logic [NPIN-1:0] IDLE = 5'b11100;

  logic [NPIN-1:0] pins;
  logic [NPIN-1:0] sync_q [SYNC_STAGES];
  logic [NPIN-1:0] lvl, prev_q;

  assign pins = {zero_n, load_n, frame_n, ser_dat, ser_clk};

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q[g] <= IDLE;
        else        sync_q[g] <= pins;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q[g] <= IDLE;
        else        sync_q[g] <= sync_q[g-1];
    end
  end

  assign lvl = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= IDLE;
    else        prev_q <= lvl;

  logic sclk_rise, cs_rise, ld_fall, clr_fall, clr_lvl, clr_prev, ld_lvl;
  logic shift_en, xfer;

  assign sclk_rise = lvl[0] & ~prev_q[0];
  assign cs_rise   = lvl[2] & ~prev_q[2];
  assign ld_fall   = ~lvl[3] & prev_q[3];
  assign clr_fall  = ~lvl[4] & prev_q[4];
  assign clr_lvl   = lvl[4];
  assign clr_prev  = prev_q[4];
  assign ld_lvl    = lvl[3];
  assign shift_en  = sclk_rise & ~lvl[2];
  assign xfer      = clr_lvl & ((cs_rise & ~ld_lvl) | ld_fall);

  logic [WIDTH-1:0] shift_q;

  always_ff @(posedge clk)
    if (clr_fall)      shift_q <= '0;
    else if (shift_en) shift_q <= {shift_q[WIDTH-2:0], lvl[1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dac_code   <= '0;
      dac_update <= 1'b0;
    end else begin
      dac_update <= clr_fall | xfer;
      if (clr_fall)  dac_code <= '0;
      else if (xfer) dac_code <= shift_q;
    end

  for (genvar i = 0; i < SEGS; i++) begin : g_seg
    assign seg_en[i] = int'(dac_code[WIDTH-1 -: SEG_BITS]) > i;
  end

  assign ladder_sw = dac_code[WIDTH-SEG_BITS-1:0];
endmodule

// File: rtl/sdac_front_chk.sv
module sdac_front_chk #(
  parameter int WIDTH    = 16,
  parameter int SEG_BITS = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [WIDTH-1:0]         dac_code,
  input logic [(2**SEG_BITS)-2:0] seg_en,
  input logic                     dac_update,
  input logic                     cs_rise,
  input logic                     ld_lvl,
  input logic                     clr_fall,
  input logic                     clr_lvl,
  input logic                     clr_prev
);
  localparam int SEGS = (2**SEG_BITS) - 1;

  assert_code_moves_with_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code != $past(dac_code)) |-> dac_update);

  assert_hold_when_load_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && ld_lvl && clr_lvl) |=> !dac_update);

  assert_clear_zeroes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fall |=> (dac_code == '0 && dac_update));

  assert_clear_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_lvl && !clr_prev) |=> !dac_update);

  assert_thermometer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(seg_en) == int'(dac_code[WIDTH-1 -: SEG_BITS])) &&
    ((seg_en & (seg_en + {{(SEGS-1){1'b0}}, 1'b1})) == '0));
endmodule

bind sdac_front sdac_front_chk #(.WIDTH(WIDTH), .SEG_BITS(SEG_BITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .dac_code(dac_code), .seg_en(seg_en),
  .dac_update(dac_update), .cs_rise(cs_rise), .ld_lvl(ld_lvl),
  .clr_fall(clr_fall), .clr_lvl(clr_lvl), .clr_prev(clr_prev));

// File: tb/sdac_front_tb_top.sv
module sdac_front_tb_top;
  logic clk = 0, rst_n = 0;
  logic ser_clk = 0, ser_dat = 0, frame_n = 1, load_n = 1, zero_n = 1;
  logic [15:0] dac_code;
  logic [14:0] seg_en;
  logic [11:0] ladder_sw;
  logic dac_update;

  int vectors = 0, fails = 0, pulses = 0, exp_pulses = 0;
  logic [15:0] exp_shift = '0, exp_dac = '0;

  always #5 clk = ~clk;

  sdac_front dut_i (.clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .frame_n(frame_n), .load_n(load_n), .zero_n(zero_n), .dac_code(dac_code),
    .seg_en(seg_en), .ladder_sw(ladder_sw), .dac_update(dac_update));

  always @(negedge clk) if (rst_n && dac_update) pulses++;

  function automatic logic [14:0] therm(input logic [3:0] k);
    for (int i = 0; i < 15; i++) therm[i] = (i < int'(k));
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    cmp(req, 32'(dac_code), 32'(exp_dac));
    cmp({req, "/R9 seg"}, 32'(seg_en), 32'(therm(exp_dac[15:12])));
    cmp({req, "/R9 ladder"}, 32'(ladder_sw), 32'(exp_dac[11:0]));
    cmp({req, " pulses"}, 32'(pulses), 32'(exp_pulses));
  endtask

  // mode 0: load high at frame end; 1: load falls with frame rise; 2: load low across frame
  task automatic send_frame(input logic [31:0] bits, input int n, input int mode, input int clr_at);
    if (mode == 2) begin
      load_n = 0; exp_dac = exp_shift; exp_pulses++; tick(6);
    end
    frame_n = 0; tick(3);
    for (int i = 0; i < n; i++) begin
      if (i == clr_at) begin
        zero_n = 0; exp_shift = '0; exp_dac = '0; exp_pulses++; tick(6);
        zero_n = 1; tick(6);
      end
      ser_dat = bits[n-1-i]; tick(3);
      ser_clk = 1; exp_shift = {exp_shift[14:0], bits[n-1-i]}; tick(3);
      ser_clk = 0; tick(2);
    end
    tick(3);
    if (mode == 1) load_n = 0;
    frame_n = 1;
    if (mode != 0) begin exp_dac = exp_shift; exp_pulses++; end
    tick(6);
    load_n = 1; tick(6);
  endtask

  task automatic load_pulse(input bit counts);
    load_n = 0;
    if (counts) begin exp_dac = exp_shift; exp_pulses++; end
    tick(6); load_n = 1; tick(6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    tick(3);
    check_all("R1 in reset");
    rst_n = 1; tick(4);
    check_all("R1 after reset");

    send_frame(32'hA5C3, 16, 0, -1);
    check_all("R6 load high keeps code");
    load_pulse(1);
    check_all("R6 load pulse transfers");

    send_frame(32'h1234, 16, 1, -1);
    check_all("R5 coincident load and frame");

    // R2: serial clock edges with frame high are ignored
    ser_dat = 1;
    for (int i = 0; i < 3; i++) begin ser_clk = 1; tick(3); ser_clk = 0; tick(3); end
    load_pulse(1);
    check_all("R2 idle clocks ignored");

    send_frame(32'h3_BEEF, 20, 1, -1);
    check_all("R3 overlong frame");

    send_frame(32'h5, 4, 2, -1);
    check_all("R4 short frame stale bits");

    // R5 latency
    send_frame(32'h8001, 16, 0, -1);
    begin
      logic [15:0] old;
      old = exp_dac;
      load_n = 0; tick(2);
      cmp("R5 before third edge", 32'(dac_code), 32'(old));
      tick(1);
      exp_dac = exp_shift; exp_pulses++;
      cmp("R5 at third edge", 32'(dac_code), 32'(exp_dac));
      tick(3); load_n = 1; tick(6);
      check_all("R5 latency");
    end

    send_frame(32'hFFFF, 16, 1, 7);
    check_all("R7 clear mid frame");

    // R8: clear held low blocks transfers
    zero_n = 0; exp_shift = '0; exp_dac = '0; exp_pulses++; tick(6);
    check_all("R7 clear zeroes");
    send_frame(32'hC0DE, 16, 0, -1);
    load_pulse(0);
    frame_n = 0; tick(3); load_n = 0; frame_n = 1; tick(6); load_n = 1; tick(6);
    check_all("R8 blocked while clear low");
    zero_n = 1; tick(6);
    check_all("R8 release no transfer");
    load_pulse(1);
    check_all("R8 transfer after release");

    // R9 segment extremes
    send_frame(32'hF000, 16, 1, -1);
    check_all("R9 top segment");
    send_frame(32'h0FFF, 16, 1, -1);
    check_all("R9 ladder only");

    // random mix
    for (int k = 0; k < 40; k++) begin
      int n, mode, ca;
      logic [31:0] b;
      n = 12 + int'($urandom_range(0, 8));
      mode = int'($urandom_range(0, 2));
      ca = ($urandom_range(0, 5) == 0) ? int'($urandom_range(0, 11)) : -1;
      b = $urandom();
      send_frame(b, n, mode, ca);
      if (mode == 0 && $urandom_range(0, 1) == 1) load_pulse(1);
      check_all("R2 R3 R4 R5 R6 R7 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule